// File: doc/BRIEF.md
# Complement-Shadowed Configuration Register

This block keeps a device configuration word safe from upsets in single storage cells. After reset it accepts one word from a load port that stands in for the non-volatile configuration source. The word goes into a primary register, and its bitwise inverse goes into a second, shadow register. From then on the word is locked. A later reset is the only way to load it again.

On every clock the two copies are XORed. In a healthy state every bit of the result is one. If any bit is zero, a sticky fault flag is set and a reset request is raised for exactly one cycle, which the device reset controller acts on. A fault-injection port XORs a mask into one of the two copies, so the detection path can be exercised from a bench.

Top module: `cfg_shadow_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cfg_value` is zero and `cfg_valid`, `fault` and `reset_req` are low.
- R2: The first clock edge after reset that samples `load_en` high stores `load_data`. From the next cycle `cfg_value` equals that word and `cfg_valid` is high.
- R3: Once `cfg_valid` is high, `load_en` has no effect on `cfg_value` until the next reset.
- R4: The shadow register holds the exact inverse of the primary register. With no injection, `fault` stays low for any loaded word, and also before any load.
- R5: An injection with `inj_sel`=0 XORs `inj_mask` into the primary copy at the sampling edge. From the next cycle `cfg_value` shows the XORed word.
- R6: An injection with `inj_sel`=1 XORs `inj_mask` into the shadow copy. `cfg_value` does not change.
- R7: After an injection that flips any single bit of either copy, `fault` and `reset_req` go high on the second edge after the injection is sampled. They are not high on the first edge.
- R8: `reset_req` stays high for exactly one cycle per fault. It does not rise again while `fault` is set.
- R9: `fault` stays high until reset, even if a later injection makes the two copies complementary again.
- R10: An injection with an all-zero mask changes nothing, and no fault follows.
- R11: If a load and an injection are sampled on the same edge, the load takes effect and the injection is dropped.
- R12: Reset clears `fault`, drops `cfg_valid` and permits a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load strobe from the configuration source |
| load_data | input | CFG_W | Configuration word to store |
| inj_en | input | 1 | Fault-injection strobe |
| inj_sel | input | 1 | Injection target: 0 primary, 1 shadow |
| inj_mask | input | CFG_W | Bits to flip in the selected copy |
| cfg_value | output | CFG_W | Stored configuration word (primary copy) |
| cfg_valid | output | 1 | Word loaded and locked |
| fault | output | 1 | Sticky mismatch flag |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The bench sweeps every bit position of an 8-bit configuration over several loaded words, with injection into both copies. A comparator missing one bit, or a shadow that keeps a copy instead of the inverse, would then either miss a flip or fault with no injection. It checks the exact cycle in which `fault` and `reset_req` appear and that the request drops after one cycle. A level-style request, or a flag that clears when a second flip restores the copies, would fail those checks. It also tries a second load after locking, a zero mask, a load and an injection on the same edge, and a reset followed by a reload, which catch a missing lock, dropped load priority, or state that survives reset.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic {
    TGT_PRIMARY = 1'b0,
    TGT_SHADOW  = 1'b1
  } inj_tgt_e;
endpackage

// File: rtl/cfgs_ctrl.sv
module cfgs_ctrl
  import cfgs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  input  logic inj_en,
  input  logic inj_sel,
  output logic load_now,
  output logic inj_prim,
  output logic inj_shad,
  output logic locked
);
  logic locked_q;

  assign load_now = load_en & ~locked_q;
  assign inj_prim = inj_en & ~load_now & (inj_tgt_e'(inj_sel) == TGT_PRIMARY);
  assign inj_shad = inj_en & ~load_now & (inj_tgt_e'(inj_sel) == TGT_SHADOW);

  always_ff @(posedge clk) begin
    if (rst)           locked_q <= 1'b0;
    else if (load_now) locked_q <= 1'b1;
  end

  assign locked = locked_q;
endmodule

// File: rtl/cfgs_store.sv
module cfgs_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_now,
  input  logic [W-1:0] load_data,
  input  logic         inj_prim,
  input  logic         inj_shad,
  input  logic [W-1:0] inj_mask,
  output logic [W-1:0] prim,
  output logic [W-1:0] shad
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic p_q, s_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q <= 1'b0;
        s_q <= 1'b1;
      end else if (load_now) begin
        p_q <= load_data[i];
        s_q <= ~load_data[i];
      end else begin
        if (inj_prim) p_q <= p_q ^ inj_mask[i];
        if (inj_shad) s_q <= s_q ^ inj_mask[i];
      end
    end
    assign prim[i] = p_q;
    assign shad[i] = s_q;
  end
endmodule

// File: rtl/cfgs_cmp.sv
module cfgs_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] prim,
  input  logic [W-1:0] shad,
  output logic         mismatch
);
  logic [W-1:0] pair_ok;
  assign pair_ok  = prim ^ shad;
  assign mismatch = ~(&pair_ok);
endmodule

// File: rtl/cfgs_fault.sv
module cfgs_fault (
  input  logic clk,
  input  logic rst,
  input  logic mismatch,
  output logic fault,
  output logic reset_req
);
  logic fault_q, req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      fault_q <= fault_q | mismatch;
      req_q   <= mismatch & ~fault_q;
    end
  end

  assign fault     = fault_q;
  assign reset_req = req_q;
endmodule

// File: rtl/cfg_shadow_guard.sv
module cfg_shadow_guard #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CFG_W-1:0] load_data,
  input  logic             inj_en,
  input  logic             inj_sel,
  input  logic [CFG_W-1:0] inj_mask,
  output logic [CFG_W-1:0] cfg_value,
  output logic             cfg_valid,
  output logic             fault,
  output logic             reset_req
);
  logic load_now, inj_prim, inj_shad, locked, mismatch;
  logic [CFG_W-1:0] prim, shad;

  cfgs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .load_en(load_en), .inj_en(inj_en), .inj_sel(inj_sel),
    .load_now(load_now), .inj_prim(inj_prim), .inj_shad(inj_shad), .locked(locked)
  );

  cfgs_store #(.W(CFG_W)) u_store (
    .clk(clk), .rst(rst), .load_now(load_now), .load_data(load_data),
    .inj_prim(inj_prim), .inj_shad(inj_shad), .inj_mask(inj_mask),
    .prim(prim), .shad(shad)
  );

  cfgs_cmp #(.W(CFG_W)) u_cmp (.prim(prim), .shad(shad), .mismatch(mismatch));

  cfgs_fault u_fault (
    .clk(clk), .rst(rst), .mismatch(mismatch), .fault(fault), .reset_req(reset_req)
  );

  assign cfg_value = prim;
  assign cfg_valid = locked;
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic             inj_en,
  input logic             inj_sel,
  input logic [CFG_W-1:0] inj_mask,
  input logic [CFG_W-1:0] cfg_value,
  input logic             cfg_valid,
  input logic             fault,
  input logic             reset_req
);
  p_req_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  p_req_with_fault_rise_r7: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> fault);

  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> cfg_valid);

  p_value_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !(inj_en && !inj_sel && (inj_mask != '0))) |=> $stable(cfg_value));

  p_shadow_inj_no_value_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !load_en && inj_en && inj_sel) |=> $stable(cfg_value));
endmodule

bind cfg_shadow_guard cfgs_checker #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .inj_en(inj_en), .inj_sel(inj_sel),
  .inj_mask(inj_mask), .cfg_value(cfg_value), .cfg_valid(cfg_valid),
  .fault(fault), .reset_req(reset_req)
);

// File: tb/sim_cfg_shadow_guard.sv
module sim_cfg_shadow_guard;
  localparam int W = 8;
  logic clk = 0, rst = 1, load_en = 0, inj_en = 0, inj_sel = 0;
  logic [W-1:0] load_data = '0, inj_mask = '0;
  logic [W-1:0] cfg_value;
  logic cfg_valid, fault, reset_req;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_shadow_guard #(.CFG_W(W)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; load_en = 0; inj_en = 0;
    step(); step();
    rst = 0;
  endtask

  task automatic do_load(logic [W-1:0] d);
    load_en = 1; load_data = d; step(); load_en = 0;
  endtask

  task automatic inject(logic sel, logic [W-1:0] m);
    inj_en = 1; inj_sel = sel; inj_mask = m; step(); inj_en = 0; inj_mask = '0;
  endtask

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    @(negedge clk); step();
    // R1 during reset
    chk("R1", {cfg_value, cfg_valid, fault, reset_req}, '0);
    rst = 0;
    chk("R1", {cfg_value, cfg_valid, fault, reset_req}, '0);
    // R4 before load
    repeat (3) step();
    chk("R4", fault, 0);

    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int b = 0; b < W; b++) begin
          do_reset();
          do_load(pats[p]);
          chk("R2", {cfg_value, cfg_valid}, {pats[p], 1'b1});
          step();
          chk("R4", fault, 0);
          inject(s[0], W'(1) << b);
          chk("R5", cfg_value, s == 0 ? pats[p] ^ (W'(1) << b) : pats[p]);
          chk("R7", {fault, reset_req}, 2'b00);
          step();
          chk("R7", {fault, reset_req}, 2'b11);
          step();
          chk("R8", {fault, reset_req}, 2'b10);
          inject(s[0], W'(1) << b);  // copies complementary again
          step(); step();
          chk("R9", {fault, reset_req}, 2'b10);
        end
      end
    end

    // R6 shadow injection leaves value alone
    do_reset(); do_load(8'h5A); inject(1, 8'hFF);
    chk("R6", cfg_value, 8'h5A);
    // R3 second load ignored
    do_reset(); do_load(8'h12); do_load(8'h34);
    chk("R3", {cfg_value, cfg_valid}, {8'h12, 1'b1});
    step(); chk("R3", fault, 0);
    // R10 zero mask
    inject(0, 8'h00); inject(1, 8'h00); step(); step();
    chk("R10", {cfg_value, fault, reset_req}, {8'h12, 2'b00});
    // R11 load with injection same edge
    do_reset();
    load_en = 1; load_data = 8'hC3; inj_en = 1; inj_sel = 0; inj_mask = 8'h01;
    step(); load_en = 0; inj_en = 0; inj_mask = '0;
    chk("R11", cfg_value, 8'hC3);
    step(); step();
    chk("R11", fault, 0);
    // R12 reset clears fault and allows reload
    inject(0, 8'h80); step(); step();
    chk("R12", fault, 1);
    do_reset();
    chk("R12", {fault, cfg_valid}, 2'b00);
    do_load(8'h77);
    chk("R12", {cfg_value, cfg_valid}, {8'h77, 1'b1});
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule